// File: doc/BRIEF.md
# Debug APB Memory Access Port

This block sits on the debug side of a chip and turns register accesses from an upstream debug transport into single-word APB4 transfers. The upstream side sees three registers. The control word holds the protection bits, the error policy, the address-increment mode and live authentication status. The target address register holds the address of the next transfer. Any read or write of the data register launches one word transfer on the APB master port, and the result comes back as a single-cycle response that carries read data and an error flag.

Every data access is checked against the debug authentication inputs before it can reach the bus. A Secure transfer needs more than a Non-secure one. A refused access never asserts `psel`, and it answers upstream with an error at once. An error response from the bus sets a sticky flag. When stop-on-error is enabled, that flag blocks every later data access until software clears it by writing 1. Auto-increment advances the target address by one word, but only after a clean transfer.

Top module: `dbg_apb_port`

## Requirements
- R1: After reset, a read of the control word (selector 0) returns 0x3000_0002 with bits 6 and 23 ORed in as described in R4, and a read of the target address (selector 1) returns 0.
- R2: Control bits [30:28] reset to 0b011. Writes to them are stored, and the stored value drives `pprot[2:0]` during each transfer started while it is held.
- R3: A data access (selector 3) is issued on the bus only when `dbgen` is high and either `spiden` is high or protection bit [1] is 1. Bit [1] equal to 0 means a Secure access. Any other data access is answered next cycle with `resp_err`=1 and `resp_rdata`=0, and `psel` is not asserted.
- R4: Control bit 6 reads as `dbgen | niden` and control bit 23 reads as `spiden | spniden`. When bit 6 is low, no transfer is issued. When bit 23 is low, Secure transfers are refused.
- R5: A transfer asserts `psel` with `penable` low for one cycle, then raises `penable`, and holds both signals with `paddr` and `pprot` stable until `pready`. The response appears in the cycle after `pready`, which makes it three cycles after acceptance when there are no wait states.
- R6: A data read returns `prdata` in `resp_rdata`. A data write drives the upstream write data on `pwdata`, with `paddr` equal to the target address.
- R7: The increment field is control bits [5:4]. When it equals 1, the target address increases by 4 after a transfer that ends without `pslverr`. With values 0, 2 and 3, or after an error, the address is unchanged.
- R8: A transfer that ends with `pslverr` sets the sticky error flag at control bit 18. Writing 1 to bit 18 clears it, and writing 0 leaves it unchanged.
- R9: When stop-on-error (control bit 17) is 1 and the sticky flag is set, every data access is refused as in R3 without asserting `psel`. After the flag is cleared, data accesses proceed again.
- R10: With control bit 16 set to 1, a bus error is not reported in `resp_err` but still sets the sticky flag. With bit 16 set to 0, it is reported.
- R11: Control bits [2:0] always read 0b010. Bits [15:8], bit 31, bit 3 and bits [22:19] always read 0, whatever is written.
- R12: Accesses to the control and target address registers respond in the next cycle and start no transfer. `req_ready` is low for as long as a transfer is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dbgen | input | 1 | Invasive debug enable |
| niden | input | 1 | Non-invasive debug enable |
| spiden | input | 1 | Secure invasive debug enable |
| spniden | input | 1 | Secure non-invasive debug enable |
| req_valid | input | 1 | Upstream request valid |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_write | input | 1 | 1 = register write, 0 = register read |
| req_sel | input | 2 | Register select: 0 control, 1 target address, 3 data |
| req_wdata | input | DW | Upstream write data |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_rdata | output | DW | Response read data |
| resp_err | output | 1 | Response error |
| psel | output | 1 | APB select |
| penable | output | 1 | APB enable |
| pwrite | output | 1 | APB write |
| paddr | output | AW | APB address |
| pwdata | output | DW | APB write data |
| pprot | output | 3 | APB protection |
| prdata | input | DW | APB read data |
| pready | input | 1 | APB ready |
| pslverr | input | 1 | APB slave error |

## Verification
The assertions check the bus handshake on every cycle: setup before access, the hold through wait states, and `req_ready` staying low while a transfer is outstanding. They also check on every cycle that no `psel` rises unless the authentication and stop-on-error conditions allowed it, that a bus error always sets the sticky flag, and that the address steps after clean incrementing transfers. Some behaviours can only be shown by the bench's scenarios: the exact control-word readback, suppression of reported errors, write-1-to-clear, resuming after stop-on-error, the reserved increment values and the response latency with wait states.

// File: rtl/dap_pkg.sv
package dap_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETUP  = 2'd1,
    ST_ACCESS = 2'd2
  } apb_st_t;

  localparam logic [1:0] SEL_CTRL  = 2'd0;
  localparam logic [1:0] SEL_TADDR = 2'd1;
  localparam logic [1:0] SEL_DATA  = 2'd3;

  localparam int B_PROT_LO  = 28;
  localparam int B_SDEV     = 23;
  localparam int B_STICKY   = 18;
  localparam int B_ERRSTOP  = 17;
  localparam int B_ERRNPASS = 16;
  localparam int B_BUSY     = 7;
  localparam int B_DEV      = 6;
  localparam int B_INC_LO   = 4;

  localparam logic [2:0] PROT_RST  = 3'b011;
  localparam logic [2:0] SIZE_WORD = 3'b010;
  localparam logic [1:0] INC_SINGLE = 2'b01;
endpackage

// File: rtl/dap_regs.sv
module dap_regs
  import dap_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_ctrl,
  input  logic          wr_taddr,
  input  logic [DW-1:0] wdata,
  input  logic          xfer_done,
  input  logic          xfer_err,
  output logic [2:0]    prot,
  output logic          errstop,
  output logic          errnpass,
  output logic          sticky,
  output logic [1:0]    inc_mode,
  output logic [AW-1:0] taddr
);
  localparam logic [AW-1:0] STEP = AW'(DW / 8);

  always_ff @(posedge clk) begin
    if (rst) begin
      prot     <= PROT_RST;
      errstop  <= 1'b0;
      errnpass <= 1'b0;
      inc_mode <= 2'b00;
    end else if (wr_ctrl) begin
      prot     <= wdata[B_PROT_LO +: 3];
      errstop  <= wdata[B_ERRSTOP];
      errnpass <= wdata[B_ERRNPASS];
      inc_mode <= wdata[B_INC_LO +: 2];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sticky <= 1'b0;
    end else if (xfer_done && xfer_err) begin
      sticky <= 1'b1;
    end else if (wr_ctrl && wdata[B_STICKY]) begin
      sticky <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      taddr <= '0;
    end else if (wr_taddr) begin
      taddr <= wdata[AW-1:0];
    end else if (xfer_done && !xfer_err && inc_mode == INC_SINGLE) begin
      taddr <= taddr + STEP;
    end
  end
endmodule

// File: rtl/dap_gate.sv
module dap_gate (
  input  logic       dbgen,
  input  logic       niden,
  input  logic       spiden,
  input  logic       spniden,
  input  logic [2:0] prot,
  input  logic       errstop,
  input  logic       sticky,
  output logic       dev_en,
  output logic       sdev_en,
  output logic       permit
);
  logic nonsecure;
  logic auth_ok;
  logic blocked;

  always_comb begin
    dev_en    = dbgen | niden;
    sdev_en   = spiden | spniden;
    nonsecure = prot[1];
    auth_ok   = dbgen && (spiden || nonsecure);
    blocked   = errstop && sticky;
    permit    = dev_en && (nonsecure || sdev_en) && auth_ok && !blocked;
  end
endmodule

// File: rtl/dap_apb_master.sv
module dap_apb_master
  import dap_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          start_write,
  input  logic [AW-1:0] start_addr,
  input  logic [DW-1:0] start_wdata,
  input  logic [2:0]    start_prot,
  output logic          psel,
  output logic          penable,
  output logic          pwrite,
  output logic [AW-1:0] paddr,
  output logic [DW-1:0] pwdata,
  output logic [2:0]    pprot,
  input  logic          pready,
  input  logic          pslverr,
  input  logic [DW-1:0] prdata,
  output logic          busy,
  output logic          done,
  output logic          done_err,
  output logic [DW-1:0] done_rdata
);
  apb_st_t state;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      pwrite <= 1'b0;
      paddr  <= '0;
      pwdata <= '0;
      pprot  <= PROT_RST;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start) begin
            state  <= ST_SETUP;
            pwrite <= start_write;
            paddr  <= start_addr;
            pwdata <= start_wdata;
            pprot  <= start_prot;
          end
        end
        ST_SETUP:  state <= ST_ACCESS;
        ST_ACCESS: if (pready) state <= ST_IDLE;
        default:   state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    psel       = (state != ST_IDLE);
    penable    = (state == ST_ACCESS);
    busy       = psel;
    done       = (state == ST_ACCESS) && pready;
    done_err   = pslverr;
    done_rdata = pwrite ? '0 : prdata;
  end
endmodule

// File: rtl/dbg_apb_port.sv
module dbg_apb_port
  import dap_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          dbgen,
  input  logic          niden,
  input  logic          spiden,
  input  logic          spniden,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [1:0]    req_sel,
  input  logic [DW-1:0] req_wdata,
  output logic          resp_valid,
  output logic [DW-1:0] resp_rdata,
  output logic          resp_err,
  output logic          psel,
  output logic          penable,
  output logic          pwrite,
  output logic [AW-1:0] paddr,
  output logic [DW-1:0] pwdata,
  output logic [2:0]    pprot,
  input  logic [DW-1:0] prdata,
  input  logic          pready,
  input  logic          pslverr
);
  logic [2:0]    prot_q;
  logic          errstop_q, errnpass_q, sticky_q;
  logic [1:0]    inc_w;
  logic [AW-1:0] taddr_w;
  logic          dev_en, sdev_en, permit;
  logic          busy_w, done_w, doneerr_w;
  logic [DW-1:0] donerd_w;
  logic [DW-1:0] ctrl_word;
  logic          accept, is_data, start_xfer, refuse;
  logic          wr_ctrl, wr_taddr;

  always_comb begin
    req_ready  = !busy_w;
    accept     = req_valid && req_ready;
    is_data    = (req_sel == SEL_DATA);
    start_xfer = accept && is_data && permit;
    refuse     = accept && is_data && !permit;
    wr_ctrl    = accept && req_write && (req_sel == SEL_CTRL);
    wr_taddr   = accept && req_write && (req_sel == SEL_TADDR);
  end

  always_comb begin
    ctrl_word                  = '0;
    ctrl_word[B_PROT_LO +: 3]  = prot_q;
    ctrl_word[B_SDEV]          = sdev_en;
    ctrl_word[B_STICKY]        = sticky_q;
    ctrl_word[B_ERRSTOP]       = errstop_q;
    ctrl_word[B_ERRNPASS]      = errnpass_q;
    ctrl_word[B_BUSY]          = busy_w;
    ctrl_word[B_DEV]           = dev_en;
    ctrl_word[B_INC_LO +: 2]   = inc_w;
    ctrl_word[2:0]             = SIZE_WORD;
  end

  dap_regs #(.AW(AW), .DW(DW)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .wr_ctrl   (wr_ctrl),
    .wr_taddr  (wr_taddr),
    .wdata     (req_wdata),
    .xfer_done (done_w),
    .xfer_err  (doneerr_w),
    .prot      (prot_q),
    .errstop   (errstop_q),
    .errnpass  (errnpass_q),
    .sticky    (sticky_q),
    .inc_mode  (inc_w),
    .taddr     (taddr_w)
  );

  dap_gate u_gate (
    .dbgen   (dbgen),
    .niden   (niden),
    .spiden  (spiden),
    .spniden (spniden),
    .prot    (prot_q),
    .errstop (errstop_q),
    .sticky  (sticky_q),
    .dev_en  (dev_en),
    .sdev_en (sdev_en),
    .permit  (permit)
  );

  dap_apb_master #(.AW(AW), .DW(DW)) u_apb (
    .clk         (clk),
    .rst         (rst),
    .start       (start_xfer),
    .start_write (req_write),
    .start_addr  (taddr_w),
    .start_wdata (req_wdata),
    .start_prot  (prot_q),
    .psel        (psel),
    .penable     (penable),
    .pwrite      (pwrite),
    .paddr       (paddr),
    .pwdata      (pwdata),
    .pprot       (pprot),
    .pready      (pready),
    .pslverr     (pslverr),
    .prdata      (prdata),
    .busy        (busy_w),
    .done        (done_w),
    .done_err    (doneerr_w),
    .done_rdata  (donerd_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      resp_valid <= 1'b0;
      resp_rdata <= '0;
      resp_err   <= 1'b0;
    end else begin
      resp_valid <= (accept && !start_xfer) || done_w;
      if (done_w) begin
        resp_rdata <= donerd_w;
        resp_err   <= doneerr_w && !errnpass_q;
      end else if (accept) begin
        resp_err <= refuse;
        if (req_write || is_data) resp_rdata <= '0;
        else if (req_sel == SEL_CTRL) resp_rdata <= ctrl_word;
        else if (req_sel == SEL_TADDR) resp_rdata <= DW'(taddr_w);
        else resp_rdata <= '0;
      end
    end
  end
endmodule

// File: rtl/dap_checker.sv
module dap_checker #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          psel,
  input logic          penable,
  input logic          pready,
  input logic [AW-1:0] paddr,
  input logic [2:0]    pprot,
  input logic          dbgen,
  input logic          spiden,
  input logic          req_ready,
  input logic          errstop,
  input logic          sticky,
  input logic          xfer_done,
  input logic          xfer_err,
  input logic [1:0]    inc_mode,
  input logic [AW-1:0] taddr
);
  localparam logic [AW-1:0] STEP = AW'(4);

  assert_setup_first_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(psel) |-> !penable);

  assert_access_next_R5: assert property (@(posedge clk) disable iff (rst)
    (psel && !penable) |=> (psel && penable));

  assert_wait_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (psel && penable && !pready) |=> (psel && penable && $stable(paddr) && $stable(pprot)));

  assert_permit_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(psel) |-> ($past(dbgen) && ($past(spiden) || pprot[1])));

  assert_stop_block_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(psel) |-> !($past(errstop) && $past(sticky)));

  assert_busy_R12: assert property (@(posedge clk) disable iff (rst)
    psel |-> !req_ready);

  assert_addr_step_R7: assert property (@(posedge clk) disable iff (rst)
    (xfer_done && !xfer_err && inc_mode == 2'b01) |=> (taddr == $past(taddr) + STEP));

  assert_sticky_set_R8: assert property (@(posedge clk) disable iff (rst)
    (xfer_done && xfer_err) |=> sticky);
endmodule

bind dbg_apb_port dap_checker #(.AW(AW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .psel      (psel),
  .penable   (penable),
  .pready    (pready),
  .paddr     (paddr),
  .pprot     (pprot),
  .dbgen     (dbgen),
  .spiden    (spiden),
  .req_ready (req_ready),
  .errstop   (errstop_q),
  .sticky    (sticky_q),
  .xfer_done (done_w),
  .xfer_err  (doneerr_w),
  .inc_mode  (inc_w),
  .taddr     (taddr_w)
);

// File: tb/tb_dbg_apb_port.sv
`timescale 1ns/1ps
module tb_dbg_apb_port;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic dbgen = 1'b1, niden = 1'b0, spiden = 1'b0, spniden = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [1:0] req_sel = 2'd0;
  logic [31:0] req_wdata = '0;
  logic req_ready, resp_valid, resp_err;
  logic [31:0] resp_rdata;
  logic psel, penable, pwrite;
  logic [31:0] paddr, pwdata, prdata;
  logic [2:0] pprot;
  logic pready, pslverr;

  int tests = 0;
  int fails = 0;
  int wait_cfg = 0;
  bit err_cfg = 1'b0;
  int wcnt = 0;
  int setups = 0;
  logic [2:0] last_pprot = '0;
  logic [31:0] last_waddr = '0, last_wdata = '0;

  logic [31:0] exp_data_q[$];
  bit          exp_err_q[$];
  string       exp_tag_q[$];

  always #2 clk = ~clk;

  dbg_apb_port dut (
    .clk(clk), .rst(rst), .dbgen(dbgen), .niden(niden), .spiden(spiden), .spniden(spniden),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write), .req_sel(req_sel),
    .req_wdata(req_wdata), .resp_valid(resp_valid), .resp_rdata(resp_rdata), .resp_err(resp_err),
    .psel(psel), .penable(penable), .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata),
    .pprot(pprot), .prdata(prdata), .pready(pready), .pslverr(pslverr)
  );

  // APB slave model
  assign pready  = psel && penable && (wcnt == wait_cfg);
  assign pslverr = pready && err_cfg;
  assign prdata  = {paddr[15:0], 16'hC0DE};

  always @(posedge clk) begin
    if (psel && penable && !pready) wcnt <= wcnt + 1;
    else wcnt <= 0;
    if (psel && !penable) begin
      setups <= setups + 1;
      last_pprot <= pprot;
    end
    if (pready && pwrite) begin
      last_waddr <= paddr;
      last_wdata <= pwdata;
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && resp_valid) begin
      tests++;
      if (exp_data_q.size() == 0) begin
        fails++;
        $display("FAIL unexpected response: actual data=%h err=%0d expected none", resp_rdata, resp_err);
      end else begin
        logic [31:0] ed;
        bit ee;
        string tg;
        ed = exp_data_q.pop_front();
        ee = exp_err_q.pop_front();
        tg = exp_tag_q.pop_front();
        if (resp_rdata !== ed || resp_err !== ee) begin
          fails++;
          $display("FAIL %s: actual data=%h err=%0d expected data=%h err=%0d",
                   tg, resp_rdata, resp_err, ed, ee);
        end
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic xact(input bit wr, input logic [1:0] sel, input logic [31:0] wd,
                      input logic [31:0] ed, input bit ee, input string tag);
    exp_data_q.push_back(ed);
    exp_err_q.push_back(ee);
    exp_tag_q.push_back(tag);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_sel = sel; req_wdata = wd;
    @(posedge clk);
    #1 req_valid = 1'b0;
  endtask

  task automatic drain();
    while (exp_data_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  function automatic logic [31:0] ctrl_exp(input logic [2:0] pr, input bit st, input bit es,
                                           input bit np, input logic [1:0] inc);
    return {1'b0, pr, 4'b0, (spiden | spniden), 4'b0, st, es, np, 8'b0,
            1'b0, (dbgen | niden), inc, 1'b0, 3'b010};
  endfunction

  task automatic latency(input int w, input int exp_n, input string tag);
    int n;
    drain();
    wait_cfg = w;
    xact(1'b0, 2'd3, '0, 32'h0000_C0DE, 1'b0, tag);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!resp_valid && n < 50);
    check(tag, 32'(n), 32'(exp_n));
    drain();
    wait_cfg = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int s0;
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    check("R1 no psel after reset", {31'b0, psel}, 32'h0);

    // R1 / R4 reset readback
    xact(1'b0, 2'd0, '0, 32'h3000_0042, 1'b0, "R1 ctrl reset");
    xact(1'b0, 2'd1, '0, 32'h0, 1'b0, "R1 taddr reset");

    // R6 / R2 / R12 basic read
    xact(1'b1, 2'd1, 32'h0000_0100, 32'h0, 1'b0, "R12 taddr write");
    xact(1'b0, 2'd3, '0, 32'h0100_C0DE, 1'b0, "R6 data read");
    @(negedge clk);
    check("R12 req_ready low in transfer", {31'b0, req_ready}, 32'h0);
    drain();
    check("R2 pprot reset value", {29'b0, last_pprot}, 32'h3);

    // R7 increment
    xact(1'b1, 2'd0, 32'h3000_0010, 32'h0, 1'b0, "R7 set inc");
    xact(1'b1, 2'd3, 32'hDEAD_BEEF, 32'h0, 1'b0, "R6 data write");
    drain();
    check("R6 write addr", last_waddr, 32'h0000_0100);
    check("R6 write data", last_wdata, 32'hDEAD_BEEF);
    xact(1'b0, 2'd1, '0, 32'h0000_0104, 1'b0, "R7 addr step");
    xact(1'b0, 2'd3, '0, 32'h0104_C0DE, 1'b0, "R7 read after step");
    xact(1'b0, 2'd1, '0, 32'h0000_0108, 1'b0, "R7 second step");
    xact(1'b1, 2'd0, 32'h3000_0020, 32'h0, 1'b0, "R7 reserved inc");
    xact(1'b0, 2'd3, '0, 32'h0108_C0DE, 1'b0, "R7 reserved read");
    xact(1'b0, 2'd1, '0, 32'h0000_0108, 1'b0, "R7 reserved no step");

    // R3 secure gating
    xact(1'b1, 2'd0, 32'h1000_0000, 32'h0, 1'b0, "R2 prot write");
    drain();
    s0 = setups;
    xact(1'b0, 2'd3, '0, 32'h0, 1'b1, "R3 secure refused");
    drain();
    check("R3 refused no psel", 32'(setups - s0), 32'h0);
    spiden = 1'b1;
    xact(1'b0, 2'd3, '0, 32'h0108_C0DE, 1'b0, "R3 secure allowed");
    drain();
    check("R2 pprot secure", {29'b0, last_pprot}, 32'h1);
    xact(1'b0, 2'd0, '0, ctrl_exp(3'b001, 0, 0, 0, 2'b00), 1'b0, "R4 bit23 spiden");
    spiden = 1'b0; spniden = 1'b1;
    xact(1'b0, 2'd0, '0, ctrl_exp(3'b001, 0, 0, 0, 2'b00), 1'b0, "R4 bit23 spniden");
    spniden = 1'b0;
    xact(1'b1, 2'd0, 32'h3000_0000, 32'h0, 1'b0, "R3 back nonsecure");
    dbgen = 1'b0; niden = 1'b1;
    drain();
    s0 = setups;
    xact(1'b0, 2'd3, '0, 32'h0, 1'b1, "R3 no dbgen refused");
    xact(1'b0, 2'd0, '0, 32'h3000_0042, 1'b0, "R4 bit6 niden");
    niden = 1'b0;
    xact(1'b0, 2'd0, '0, 32'h3000_0002, 1'b0, "R4 bit6 low");
    xact(1'b1, 2'd3, 32'h1234_5678, 32'h0, 1'b1, "R4 dev off refused");
    drain();
    check("R4 no psel when disabled", 32'(setups - s0), 32'h0);
    dbgen = 1'b1;

    // R11 fixed fields
    xact(1'b1, 2'd0, 32'hFFFF_FFFF, 32'h0, 1'b0, "R11 write ones");
    xact(1'b0, 2'd0, '0, 32'h7003_0072, 1'b0, "R11 fixed fields");

    // R8 sticky, R7 no step on error
    xact(1'b1, 2'd0, 32'h3000_0010, 32'h0, 1'b0, "R8 cfg");
    xact(1'b1, 2'd1, 32'h0000_0200, 32'h0, 1'b0, "R8 taddr");
    drain();
    err_cfg = 1'b1;
    xact(1'b0, 2'd3, '0, 32'h0200_C0DE, 1'b1, "R8 bus error reported");
    drain();
    err_cfg = 1'b0;
    xact(1'b0, 2'd1, '0, 32'h0000_0200, 1'b0, "R7 no step on error");
    xact(1'b0, 2'd0, '0, 32'h3004_0052, 1'b0, "R8 sticky set");
    xact(1'b1, 2'd0, 32'h3000_0010, 32'h0, 1'b0, "R8 write zero keeps");
    xact(1'b0, 2'd0, '0, 32'h3004_0052, 1'b0, "R8 sticky kept");
    xact(1'b0, 2'd3, '0, 32'h0200_C0DE, 1'b0, "R9 no stop when disabled");
    xact(1'b1, 2'd0, 32'h3004_0010, 32'h0, 1'b0, "R8 w1c");
    xact(1'b0, 2'd0, '0, 32'h3000_0052, 1'b0, "R8 sticky cleared");

    // R10 suppressed errors
    xact(1'b1, 2'd0, 32'h3001_0000, 32'h0, 1'b0, "R10 cfg");
    drain();
    err_cfg = 1'b1;
    xact(1'b0, 2'd3, '0, 32'h0204_C0DE, 1'b0, "R10 error suppressed");
    drain();
    err_cfg = 1'b0;
    xact(1'b0, 2'd0, '0, 32'h3005_0042, 1'b0, "R10 sticky still set");

    // R9 stop on error
    xact(1'b1, 2'd0, 32'h3006_0000, 32'h0, 1'b0, "R9 cfg");
    drain();
    err_cfg = 1'b1;
    xact(1'b0, 2'd3, '0, 32'h0204_C0DE, 1'b1, "R9 first error");
    drain();
    err_cfg = 1'b0;
    s0 = setups;
    xact(1'b0, 2'd3, '0, 32'h0, 1'b1, "R9 blocked");
    xact(1'b1, 2'd3, 32'h5555_AAAA, 32'h0, 1'b1, "R9 write blocked");
    drain();
    check("R9 blocked no psel", 32'(setups - s0), 32'h0);
    xact(1'b1, 2'd0, 32'h3006_0000, 32'h0, 1'b0, "R9 clear");
    xact(1'b0, 2'd3, '0, 32'h0204_C0DE, 1'b0, "R9 resumed");

    // R5 / R12 latency
    xact(1'b1, 2'd1, 32'h0, 32'h0, 1'b0, "R5 taddr zero");
    xact(1'b1, 2'd0, 32'h3000_0000, 32'h0, 1'b0, "R5 cfg");
    latency(0, 3, "R5 latency no wait");
    latency(3, 6, "R5 latency three waits");
    drain();
    begin
      int n;
      xact(1'b0, 2'd1, '0, 32'h0, 1'b0, "R12 reg read");
      n = 0;
      do begin
        @(negedge clk);
        n++;
      end while (!resp_valid && n < 50);
      check("R12 reg latency", 32'(n), 32'h1);
    end

    drain();
    check("scoreboard empty", 32'(exp_data_q.size()), 32'h0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule